// File: doc/BRIEF.md
# Packed 9-bit Symbol Error Corrector

This block repairs a data buffer after a Reed-Solomon decoder has found its errors. The buffer sits in a byte-wide single-port RAM inside the block. Its contents are read as a continuous stream of 9-bit symbols, so most symbols straddle a byte boundary. The decoder result arrives as one 32-bit status word and seven 32-bit error reports. One `start` pulse latches them. For every report that names a symbol inside the data area, the block reads the two bytes that hold the symbol, XORs the error pattern into them and writes both bytes back.

When the run is over, a one-cycle `done` pulse comes with the count of corrected errors, or with a flag that the message could not be corrected. Between runs, a host port loads bytes into the buffer and reads them back. This lets the buffer be filled before a correction and collected after it.

Top module: `sym9_fixer`

## Requirements
- R1: An error report carries a 1-based symbol position in bits 24:16 and a 9-bit XOR pattern in bits 8:0. The zero-based symbol index is the position minus one.
- R2: A report is skipped and leaves the buffer unchanged when its position is 0, or when its index is not smaller than the `DATA_SIZE` parameter.
- R3: For index i, the first byte touched is at address i + (i >> 3), and the pattern sits at bit offset i & 7 of the 16-bit window.
- R4: The window is little-endian. Byte a is bits 7:0 and byte a+1 is bits 15:8. The pattern, shifted left by the offset, is XORed into the window, and both bytes are written back.
- R5: The number of reports to apply is status bits 31:29. Slots 0 up to that count minus one are handled in ascending order, and each one sees the buffer as updated by the earlier slots. Slots at or beyond the count are ignored.
- R6: If status bit 0 (errors found) is clear, the run finishes with `err_count` 0 and `bad_msg` 0, and the buffer is untouched.
- R7: If bit 0 is set and status bit 1 (too many errors) is also set, the run finishes with `bad_msg` 1 and `err_count` 0, and the buffer is untouched.
- R8: On a correctable run, `err_count` equals status bits 31:29, even when some reports were skipped.
- R9: `busy` is high from the cycle after an accepted `start` up to and including the `done` cycle. `done` is high for exactly one cycle, and `err_count` and `bad_msg` are valid while it is high.
- R10: A `start` pulse while `busy` is high has no effect on the running correction or its results.
- R11: While idle, a host write stores `host_wdata` at `host_addr`, and a host read returns the byte on `host_rdata` one cycle after the address is presented. Host writes while `busy` is high are ignored.
- R12: The RAM holds (DATA_SIZE-1) + ((DATA_SIZE-1) >> 3) + 2 bytes, so the second byte of the highest valid symbol is inside the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run; sampled only while idle |
| status | input | 32 | Decoder status word: error count, too-many-errors flag, errors-found flag |
| reports | input | 224 | Seven 32-bit error reports; slot k is bits 32k+31:32k |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_count | output | 3 | Corrected error count, valid with `done` |
| bad_msg | output | 1 | Uncorrectable message, valid with `done` |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the address |

## Verification
The hardest case to reach from the ports is a chain of reports that depend on each other. Two reports hit the same symbol, or hit neighbouring symbols that share a byte, so a later read must see an earlier write. The bench sends the same position twice, which must cancel out. It also places adjacent symbols in one run and checks the whole buffer against a byte model updated in slot order. A bench-only reduced `DATA_SIZE` makes the out-of-range position reachable with a 9-bit field. The bench also puts a `start` pulse and a host write in the middle of a run.

// File: rtl/sym9_pkg.sv
package sym9_pkg;
    localparam int CNT_W        = 3;
    localparam int REPORT_SLOTS = (1 << CNT_W) - 1;
    localparam int SYM_W        = 9;
    localparam int POS_LSB      = 16;
    localparam int PAT_LSB      = 0;
    localparam int CNT_LSB      = 29;
    localparam int FOUND_BIT    = 0;
    localparam int HOPELESS_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RD_LO,
        ST_RD_HI,
        ST_WR_LO,
        ST_WR_HI,
        ST_FIN
    } seq_state_e;
endpackage

// File: rtl/sym9_ram.sv
module sym9_ram #(
    parameter int DEPTH  = 576,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/sym9_locate.sv
module sym9_locate
    import sym9_pkg::*;
#(
    parameter int DATA_SIZE = 512,
    parameter int ADDR_W    = 10
) (
    input  logic [31:0]       report,
    output logic              ok,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        off,
    output logic [SYM_W-1:0]  pat
);
    logic [SYM_W-1:0] pos;
    logic [31:0]      idx;

    always_comb begin
        pos  = report[POS_LSB +: SYM_W];
        pat  = report[PAT_LSB +: SYM_W];
        idx  = 32'(pos) - 32'd1;
        ok   = (pos != '0) && (idx < 32'(DATA_SIZE));
        addr = ADDR_W'(idx + (idx >> 3));
        off  = idx[2:0];
    end
endmodule

// File: rtl/sym9_seq.sv
module sym9_seq
    import sym9_pkg::*;
#(
    parameter int DATA_SIZE = 512,
    parameter int ADDR_W    = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [31:0]                status,
    input  logic [REPORT_SLOTS*32-1:0] reports,
    output logic                       busy,
    output logic                       done,
    output logic [CNT_W-1:0]           err_count,
    output logic                       bad_msg,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [7:0]                 mem_wdata,
    input  logic [7:0]                 mem_rdata
);
    typedef struct packed {
        seq_state_e                        st;
        logic [REPORT_SLOTS-1:0][31:0]     rep;
        logic [CNT_W-1:0]                  cnt;
        logic [CNT_W-1:0]                  idx;
        logic [ADDR_W-1:0]                 addr;
        logic [2:0]                        off;
        logic [SYM_W-1:0]                  pat;
        logic [7:0]                        lo;
        logic [7:0]                        hi;
        logic [CNT_W-1:0]                  res;
        logic                              bad;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [31:0]       cur_rep;
    logic              loc_ok;
    logic [ADDR_W-1:0] loc_addr;
    logic [2:0]        loc_off;
    logic [SYM_W-1:0]  loc_pat;
    logic [15:0]       window;

    assign cur_rep = (int'(r_q.idx) < REPORT_SLOTS) ? r_q.rep[r_q.idx] : 32'd0;

    sym9_locate #(
        .DATA_SIZE(DATA_SIZE),
        .ADDR_W   (ADDR_W)
    ) u_locate (
        .report(cur_rep),
        .ok    (loc_ok),
        .addr  (loc_addr),
        .off   (loc_off),
        .pat   (loc_pat)
    );

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        mem_addr  = r_q.addr;
        mem_wdata = 8'd0;
        window    = {mem_rdata, r_q.lo} ^ (16'(r_q.pat) << r_q.off);

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.rep = reports;
                    r_d.idx = '0;
                    r_d.cnt = '0;
                    r_d.res = '0;
                    r_d.bad = 1'b0;
                    if (!status[FOUND_BIT]) begin
                        r_d.st = ST_FIN;
                    end else if (status[HOPELESS_BIT]) begin
                        r_d.bad = 1'b1;
                        r_d.st  = ST_FIN;
                    end else begin
                        r_d.cnt = status[CNT_LSB +: CNT_W];
                        r_d.res = status[CNT_LSB +: CNT_W];
                        r_d.st  = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (r_q.idx == r_q.cnt) begin
                    r_d.st = ST_FIN;
                end else if (loc_ok) begin
                    r_d.addr = loc_addr;
                    r_d.off  = loc_off;
                    r_d.pat  = loc_pat;
                    r_d.st   = ST_RD_LO;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_RD_LO: begin
                mem_addr = r_q.addr;
                r_d.st   = ST_RD_HI;
            end
            ST_RD_HI: begin
                mem_addr = r_q.addr + ADDR_W'(1);
                r_d.lo   = mem_rdata;
                r_d.st   = ST_WR_LO;
            end
            ST_WR_LO: begin
                mem_we    = 1'b1;
                mem_addr  = r_q.addr;
                mem_wdata = window[7:0];
                r_d.hi    = window[15:8];
                r_d.st    = ST_WR_HI;
            end
            ST_WR_HI: begin
                mem_we    = 1'b1;
                mem_addr  = r_q.addr + ADDR_W'(1);
                mem_wdata = r_q.hi;
                r_d.idx   = r_q.idx + 1'b1;
                r_d.st    = ST_SCAN;
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_FIN);
    assign err_count = r_q.res;
    assign bad_msg   = r_q.bad;
endmodule

// File: rtl/sym9_fixer.sv
module sym9_fixer
    import sym9_pkg::*;
#(
    parameter int DATA_SIZE = 512,
    parameter int RAM_DEPTH = (DATA_SIZE - 1) + ((DATA_SIZE - 1) >> 3) + 2,
    parameter int ADDR_W    = $clog2(RAM_DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [31:0]                status,
    input  logic [REPORT_SLOTS*32-1:0] reports,
    output logic                       busy,
    output logic                       done,
    output logic [CNT_W-1:0]           err_count,
    output logic                       bad_msg,
    input  logic                       host_we,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [7:0]                 host_wdata,
    output logic [7:0]                 host_rdata
);
    logic              seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [7:0]        seq_wdata;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;

    sym9_seq #(
        .DATA_SIZE(DATA_SIZE),
        .ADDR_W   (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .status   (status),
        .reports  (reports),
        .busy     (busy),
        .done     (done),
        .err_count(err_count),
        .bad_msg  (bad_msg),
        .mem_we   (seq_we),
        .mem_addr (seq_addr),
        .mem_wdata(seq_wdata),
        .mem_rdata(ram_rdata)
    );

    always_comb begin
        if (busy) begin
            ram_we    = seq_we;
            ram_addr  = seq_addr;
            ram_wdata = seq_wdata;
        end else begin
            ram_we    = host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end
    end

    sym9_ram #(
        .DEPTH (RAM_DEPTH),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    assign host_rdata = ram_rdata;
endmodule

// File: rtl/sym9_fixer_chk.sv
module sym9_fixer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] err_count,
    input logic       bad_msg,
    input logic       seq_we
);
    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done closes the busy window
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 !busy);

    // R7: a failed run reports no corrections
    a_r7_bad_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bad_msg) |-> (err_count == 3'd0));

    // R10: a run only begins from an idle start pulse
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11: sequencer writes occur only inside a run
    a_r11_seq_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |-> busy);
endmodule

bind sym9_fixer sym9_fixer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err_count(err_count),
    .bad_msg  (bad_msg),
    .seq_we   (seq_we)
);

// File: tb/test_sym9_fixer.sv
`timescale 1ns/1ps
module test_sym9_fixer;
    localparam int DS    = 100;
    localparam int DEPTH = (DS - 1) + ((DS - 1) >> 3) + 2;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   status = '0;
    logic [6:0][31:0] reps = '0;
    logic          busy, done, bad_msg;
    logic [2:0]    err_count;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    sym9_fixer #(.DATA_SIZE(DS)) i_sym9_fixer (
        .clk(clk), .rst_n(rst_n), .start(start), .status(status),
        .reports(reps), .busy(busy), .done(done), .err_count(err_count),
        .bad_msg(bad_msg), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int pos, input int pat);
        return {7'd0, 9'(pos), 7'd0, 9'(pat)};
    endfunction

    function automatic logic [31:0] st_word(input int cnt, input bit found, input bit hopeless);
        return {3'(cnt), 27'd0, hopeless, found};
    endfunction

    task automatic model_apply(input int pos, input int pat);
        int i, a;
        logic [15:0] w;
        if (pos == 0 || pos - 1 >= DS) return;
        i = pos - 1;
        a = i + (i >> 3);
        w = {model[a+1], model[a]} ^ (16'(pat) << (i & 7));
        model[a]   = w[7:0];
        model[a+1] = w[15:8];
    endtask

    task automatic host_write(input int addr, input logic [7:0] val);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(addr); host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int addr, output logic [7:0] val);
        @(negedge clk);
        host_addr = AW'(addr);
        @(negedge clk);
        val = host_rdata;
    endtask

    task automatic cmp_buf(input string req);
        int bad = 0, first = -1;
        logic [7:0] v, fv, fe;
        fv = '0; fe = '0;
        for (int k = 0; k < DEPTH; k++) begin
            host_read(k, v);
            if (v !== model[k]) begin
                if (first < 0) begin first = k; fv = v; fe = model[k]; end
                bad++;
            end
        end
        chk(bad == 0, req, $sformatf("buffer byte %0d", first), fv, fe);
    endtask

    task automatic kick(input logic [31:0] s);
        @(negedge clk);
        status = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req, input int exp_cnt, input bit exp_bad);
        int n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, "R9", "done seen", int'(done), 1);
        chk(err_count === 3'(exp_cnt), req, "err_count", err_count, exp_cnt);
        chk(bad_msg === exp_bad, req, "bad_msg", bad_msg, exp_bad);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9", "done single cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R9", "busy after reset", busy, 0);
        chk(done === 1'b0, "R9", "done after reset", done, 0);
    endtask

    task automatic t_host;
        for (int k = 0; k < DEPTH; k++) begin
            model[k] = 8'(k * 37 + 5);
            host_write(k, model[k]);
        end
        cmp_buf("R11");
    endtask

    task automatic t_no_error;
        reps = '0;
        reps[0] = mk(5, 9'h1FF);
        kick(st_word(3, 1'b0, 1'b0));
        wait_done("R6", 0, 1'b0);
        cmp_buf("R6");
    endtask

    task automatic t_hopeless;
        reps = '0;
        reps[0] = mk(7, 9'h0AA);
        reps[1] = mk(8, 9'h155);
        kick(st_word(2, 1'b1, 1'b1));
        wait_done("R7", 0, 1'b1);
        cmp_buf("R7");
    endtask

    task automatic t_single;
        reps = '0;
        reps[0] = mk(1, 9'h1A5);
        model_apply(1, 9'h1A5);
        kick(st_word(1, 1'b1, 1'b0));
        wait_done("R1", 1, 1'b0);
        cmp_buf("R4");
    endtask

    task automatic t_multi;
        reps = '0;
        reps[0] = mk(9, 9'h0F3);
        reps[1] = mk(16, 9'h1FF);
        reps[2] = mk(42, 9'h101);
        reps[3] = mk(43, 9'h07E);
        model_apply(9, 9'h0F3);
        model_apply(16, 9'h1FF);
        model_apply(42, 9'h101);
        model_apply(43, 9'h07E);
        kick(st_word(4, 1'b1, 1'b0));
        wait_done("R8", 4, 1'b0);
        cmp_buf("R3");
    endtask

    task automatic t_skip;
        reps = '0;
        reps[0] = mk(0, 9'h055);
        reps[1] = mk(DS + 1, 9'h1FF);
        kick(st_word(2, 1'b1, 1'b0));
        wait_done("R8", 2, 1'b0);
        cmp_buf("R2");
    endtask

    task automatic t_last;
        reps = '0;
        reps[0] = mk(DS, 9'h1C3);
        model_apply(DS, 9'h1C3);
        kick(st_word(1, 1'b1, 1'b0));
        wait_done("R12", 1, 1'b0);
        cmp_buf("R12");
    endtask

    task automatic t_order;
        reps = '0;
        reps[0] = mk(50, 9'h0F0);
        reps[1] = mk(50, 9'h0F0);
        reps[2] = mk(51, 9'h003);
        reps[3] = mk(60, 9'h1FF);
        reps[6] = mk(61, 9'h1FF);
        model_apply(51, 9'h003);
        kick(st_word(3, 1'b1, 1'b0));
        wait_done("R5", 3, 1'b0);
        cmp_buf("R5");
    endtask

    task automatic t_busy_ignore;
        int seen = 0;
        reps = '0;
        reps[0] = mk(2, 9'h011);
        reps[1] = mk(3, 9'h122);
        reps[2] = mk(4, 9'h033);
        model_apply(2, 9'h011);
        model_apply(3, 9'h122);
        model_apply(4, 9'h033);
        kick(st_word(3, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        status = st_word(1, 1'b1, 1'b1);
        start = 1'b1; host_we = 1'b1; host_addr = AW'(100); host_wdata = 8'hEE;
        @(negedge clk);
        start = 1'b0; host_we = 1'b0;
        wait_done("R10", 3, 1'b0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk(seen == 0, "R10", "extra done pulses", seen, 0);
        cmp_buf("R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host();
        t_no_error();
        t_hopeless();
        t_single();
        t_multi();
        t_skip();
        t_last();
        t_order();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule